// File: doc/BRIEF.md
# Line-Buffered Integer Upscaler with VGA Timing

This block turns a small handheld picture, delivered one source line at a time by an upstream capture stage, into a standard 640x480 VGA raster at 4 bits per colour. It does not hold a whole frame. Incoming lines go into a short ring of line buffers, and the VGA raster reads them back while the source is still producing the rest of its frame. The added delay is therefore a few source lines.

Scaling is done by plain replication. Each source pixel is shown on several consecutive output pixels, and each source line on several consecutive output lines. With the default settings a 160x152 source becomes 640x456 pixels. It is centred vertically, with black bands above and below. The output frame is restarted a fixed number of source lines after each source frame start. Reads therefore stay behind writes, and any drift between the two frame rates is corrected once per frame.

The capture stage drives a pixel write port, a line-done pulse and a frame-start pulse, all in the pixel clock domain. The block returns 4-bit red, green and blue and two active-low sync signals, ready for a resistor-ladder DAC.

Top module: `line_upscaler`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, the colour outputs are zero and both sync outputs are high.
- R2: Source pixel x of the displayed line appears on output columns x*H_REP to x*H_REP+H_REP-1. Every output is registered once, so it follows the internal raster position by one clock. A write stores `pixWrData` as {R[11:8], G[7:4], B[3:0]}.
- R3: Source line k is written to ring slot k mod NUM_BUFS and is shown on V_REP consecutive output lines. The write slot advances on each `srcLineDone`.
- R4: Some output lines are outside the image band. The band starts at line (V_ACTIVE - SRC_H*V_REP)/2 and is SRC_H*V_REP lines tall. Columns at or beyond SRC_W*H_REP and all blanking positions are also outside it. Outside the band every colour output is zero.
- R5: `vgaHsyncN` is low for H_SYNC clocks per line. The pulse starts H_FP clocks after the last active column. The line is SRC_W*H_REP+H_FP+H_SYNC+H_BP clocks long.
- R6: `vgaVsyncN` is low for V_SYNC whole lines. The pulse starts V_FP lines after the last active line. The frame is V_ACTIVE+V_FP+V_SYNC+V_BP lines long.
- R7: Each `srcFrameStart` arms a relock, and the relock fires on the LOCK_LAG-th `srcLineDone` after it. On the next clock the raster is at column 0 of line 0, and the relock fires only once per frame start.
- R8: After reset the colour outputs stay zero until the first relock. The sync outputs run freely during this time.
- R9: A pixel write may hit the buffer cell being displayed in the same clock. The display then shows the old content in that clock and the new content from the next read on.
- R10: `srcFrameStart` takes priority over a `srcLineDone` in the same clock. The write slot returns to 0 and does not advance, and the relock count restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pixWrEn | input | 1 | Pixel write strobe |
| pixWrAddr | input | 8 | Column of the pixel within the current source line |
| pixWrData | input | 12 | Pixel colour {R,G,B}, 4 bits each |
| srcLineDone | input | 1 | Pulse: current source line complete |
| srcFrameStart | input | 1 | Pulse: new source frame begins |
| vgaR | output | 4 | Red output |
| vgaG | output | 4 | Green output |
| vgaB | output | 4 | Blue output |
| vgaHsyncN | output | 1 | Horizontal sync, active low |
| vgaVsyncN | output | 1 | Vertical sync, active low |

## Verification
A source write can land in the very buffer cell that the raster is fetching in the same clock. The bench provokes this by watching its own model of the raster: it waits for a clock in which the displayed slot equals the write slot, part-way through a replicated pixel, and fires a write to that column. The pixel shown in that clock must keep the old value, and the remaining replicas of the same column must carry the new one. The bench also issues a frame start in the same clock as a line-done. The lines that follow must then land in slot 0 for the image to match.

// File: rtl/upsc_pkg.sv
package upsc_pkg;
  localparam int PTR_W = 8;
  typedef logic [PTR_W-1:0] ptr_t;

  typedef struct packed {
    logic active;
    logic hsyncLow;
    logic vsyncLow;
    ptr_t rdSlot;
    ptr_t rdAddr;
    ptr_t wrSlot;
  } upsc_strb_t;
endpackage

// File: rtl/upsc_ctrl.sv
module upsc_ctrl
  import upsc_pkg::*;
#(
  parameter int SRC_W    = 160,
  parameter int SRC_H    = 152,
  parameter int H_REP    = 4,
  parameter int V_REP    = 3,
  parameter int V_ACTIVE = 480,
  parameter int H_FP     = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BP     = 48,
  parameter int V_FP     = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 33,
  parameter int NUM_BUFS = 24,
  parameter int LOCK_LAG = 17
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       frameStart,
  input  logic       lineDone,
  output upsc_strb_t strb
);
  localparam int H_ACTIVE = SRC_W * H_REP;
  localparam int H_TOTAL  = H_ACTIVE + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL  = V_ACTIVE + V_FP + V_SYNC + V_BP;
  localparam int V_BORDER = (V_ACTIVE - SRC_H * V_REP) / 2;
  localparam int HC_W     = $clog2(H_TOTAL);
  localparam int VC_W     = $clog2(V_TOTAL);
  localparam int LC_W     = $clog2(LOCK_LAG + 1);

  localparam logic [HC_W-1:0] H_LAST      = HC_W'(H_TOTAL - 1);
  localparam logic [HC_W-1:0] H_ACT_END   = HC_W'(H_ACTIVE);
  localparam logic [HC_W-1:0] H_SYNC_BEG  = HC_W'(H_ACTIVE + H_FP);
  localparam logic [HC_W-1:0] H_SYNC_END  = HC_W'(H_ACTIVE + H_FP + H_SYNC);
  localparam logic [VC_W-1:0] V_LAST      = VC_W'(V_TOTAL - 1);
  localparam logic [VC_W-1:0] V_IMG_BEG   = VC_W'(V_BORDER);
  localparam logic [VC_W-1:0] V_IMG_END   = VC_W'(V_BORDER + SRC_H * V_REP);
  localparam logic [VC_W-1:0] V_SYNC_BEG  = VC_W'(V_ACTIVE + V_FP);
  localparam logic [VC_W-1:0] V_SYNC_END  = VC_W'(V_ACTIVE + V_FP + V_SYNC);
  localparam ptr_t            SLOT_LAST   = PTR_W'(NUM_BUFS - 1);
  localparam ptr_t            SUB_LAST    = PTR_W'(H_REP - 1);
  localparam ptr_t            REP_LAST    = PTR_W'(V_REP - 1);
  localparam logic [LC_W-1:0] LAG_LAST    = LC_W'(LOCK_LAG - 1);

  logic [HC_W-1:0] hCnt;
  logic [VC_W-1:0] vCnt;
  ptr_t            subCnt, pixCnt, repCnt, rdSlot, wrSlot;
  logic [LC_W-1:0] lineCnt;
  logic            armed, locked;

  logic lineEnd, frameEnd, imgLine, restartReq;

  assign lineEnd    = (hCnt == H_LAST);
  assign frameEnd   = lineEnd && (vCnt == V_LAST);
  assign imgLine    = (vCnt >= V_IMG_BEG) && (vCnt < V_IMG_END);
  assign restartReq = lineDone && !frameStart && armed && (lineCnt == LAG_LAST);

  // write side: slot ring and relock arming
  always_ff @(posedge clk) begin
    if (rst) begin
      wrSlot  <= '0;
      lineCnt <= '0;
      armed   <= 1'b0;
    end else if (frameStart) begin
      wrSlot  <= '0;
      lineCnt <= '0;
      armed   <= 1'b1;
    end else if (lineDone) begin
      wrSlot <= (wrSlot == SLOT_LAST) ? '0 : wrSlot + 1'b1;
      if (armed) begin
        lineCnt <= lineCnt + 1'b1;
        if (restartReq) armed <= 1'b0;
      end
    end
  end

  // read side: raster counters and replication counters
  always_ff @(posedge clk) begin
    if (rst || restartReq) begin
      hCnt   <= '0;
      vCnt   <= '0;
      subCnt <= '0;
      pixCnt <= '0;
      repCnt <= '0;
      rdSlot <= '0;
      locked <= !rst;
    end else if (lineEnd) begin
      hCnt   <= '0;
      subCnt <= '0;
      pixCnt <= '0;
      if (frameEnd) begin
        vCnt   <= '0;
        repCnt <= '0;
        rdSlot <= '0;
      end else begin
        vCnt <= vCnt + 1'b1;
        if (imgLine) begin
          if (repCnt == REP_LAST) begin
            repCnt <= '0;
            rdSlot <= (rdSlot == SLOT_LAST) ? '0 : rdSlot + 1'b1;
          end else begin
            repCnt <= repCnt + 1'b1;
          end
        end
      end
    end else begin
      hCnt <= hCnt + 1'b1;
      if (subCnt == SUB_LAST) begin
        subCnt <= '0;
        pixCnt <= pixCnt + 1'b1;
      end else begin
        subCnt <= subCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb.active   = locked && imgLine && (hCnt < H_ACT_END);
    strb.hsyncLow = (hCnt >= H_SYNC_BEG) && (hCnt < H_SYNC_END);
    strb.vsyncLow = (vCnt >= V_SYNC_BEG) && (vCnt < V_SYNC_END);
    strb.rdSlot   = rdSlot;
    strb.rdAddr   = pixCnt;
    strb.wrSlot   = wrSlot;
  end

  // R7
  relock_origin_chk: assert property (@(posedge clk) disable iff (rst)
    restartReq |=> (hCnt == '0 && vCnt == '0 && locked));

  // R10
  fs_slot_clear_chk: assert property (@(posedge clk) disable iff (rst)
    frameStart |=> (wrSlot == '0 && armed));

  // R3
  slot_range_chk: assert property (@(posedge clk) disable iff (rst)
    (rdSlot <= SLOT_LAST) && (wrSlot <= SLOT_LAST));
endmodule

// File: rtl/upsc_datapath.sv
module upsc_datapath
  import upsc_pkg::*;
#(
  parameter int SRC_W    = 160,
  parameter int NUM_BUFS = 24
) (
  input  logic        clk,
  input  logic        rst,
  input  upsc_strb_t  strb,
  input  logic        wrEn,
  input  ptr_t        wrAddr,
  input  logic [11:0] wrData,
  output logic [11:0] pixel,
  output logic        hsyncN,
  output logic        vsyncN
);
  localparam int   ADDR_W = $clog2(SRC_W);
  localparam ptr_t W_LIM  = PTR_W'(SRC_W);

  logic [11:0] bankQ [NUM_BUFS];
  logic        wrInRange, rdInRange, activeQ;
  ptr_t        rdSlotQ;

  assign wrInRange = wrEn && (wrAddr < W_LIM);
  assign rdInRange = strb.rdAddr < W_LIM;

  for (genvar g = 0; g < NUM_BUFS; g++) begin : g_bank
    logic [11:0] bankMem [SRC_W];
    logic [11:0] bankRd;
    always_ff @(posedge clk) begin
      if (wrInRange && strb.wrSlot == PTR_W'(g))
        bankMem[wrAddr[ADDR_W-1:0]] <= wrData;
      bankRd <= rdInRange ? bankMem[strb.rdAddr[ADDR_W-1:0]] : '0;
    end
    assign bankQ[g] = bankRd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      activeQ <= 1'b0;
      rdSlotQ <= '0;
      hsyncN  <= 1'b1;
      vsyncN  <= 1'b1;
    end else begin
      activeQ <= strb.active;
      rdSlotQ <= strb.rdSlot;
      hsyncN  <= !strb.hsyncLow;
      vsyncN  <= !strb.vsyncLow;
    end
  end

  always_comb begin
    pixel = '0;
    for (int s = 0; s < NUM_BUFS; s++)
      if (activeQ && rdSlotQ == PTR_W'(s)) pixel = bankQ[s];
  end

  // R4
  blank_black_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.active |=> (pixel == '0));

  // R5
  hsync_follow_chk: assert property (@(posedge clk) disable iff (rst)
    strb.hsyncLow |=> !hsyncN);

  // R6
  vsync_follow_chk: assert property (@(posedge clk) disable iff (rst)
    strb.vsyncLow |=> !vsyncN);
endmodule

// File: rtl/line_upscaler.sv
module line_upscaler
  import upsc_pkg::*;
#(
  parameter int SRC_W    = 160,
  parameter int SRC_H    = 152,
  parameter int H_REP    = 4,
  parameter int V_REP    = 3,
  parameter int V_ACTIVE = 480,
  parameter int H_FP     = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BP     = 48,
  parameter int V_FP     = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 33,
  parameter int NUM_BUFS = 24,
  parameter int LOCK_LAG = 17
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        pixWrEn,
  input  logic [7:0]  pixWrAddr,
  input  logic [11:0] pixWrData,
  input  logic        srcLineDone,
  input  logic        srcFrameStart,
  output logic [3:0]  vgaR,
  output logic [3:0]  vgaG,
  output logic [3:0]  vgaB,
  output logic        vgaHsyncN,
  output logic        vgaVsyncN
);
  upsc_strb_t  strb;
  logic [11:0] pixel;

  upsc_ctrl #(
    .SRC_W(SRC_W), .SRC_H(SRC_H), .H_REP(H_REP), .V_REP(V_REP),
    .V_ACTIVE(V_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .NUM_BUFS(NUM_BUFS), .LOCK_LAG(LOCK_LAG)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .frameStart(srcFrameStart), .lineDone(srcLineDone),
    .strb(strb)
  );

  upsc_datapath #(.SRC_W(SRC_W), .NUM_BUFS(NUM_BUFS)) u_dp (
    .clk(clk), .rst(rst), .strb(strb),
    .wrEn(pixWrEn), .wrAddr(pixWrAddr), .wrData(pixWrData),
    .pixel(pixel), .hsyncN(vgaHsyncN), .vsyncN(vgaVsyncN)
  );

  assign vgaR = pixel[11:8];
  assign vgaG = pixel[7:4];
  assign vgaB = pixel[3:0];
endmodule

// File: tb/line_upscaler_bench.sv
module line_upscaler_bench;
  localparam int SW = 6, SH = 4, HR = 4, VR = 3, VA = 16;
  localparam int HFP = 2, HS = 3, HBP = 3, VFP = 1, VS = 2, VBP = 2;
  localparam int NB = 4, LAG = 1;
  localparam int HA = SW * HR, HT = HA + HFP + HS + HBP;
  localparam int VT = VA + VFP + VS + VBP;
  localparam int BRD = (VA - SH * VR) / 2, IMG_END = BRD + SH * VR;

  logic clk = 0, rst = 1;
  logic pixWrEn = 0, srcLineDone = 0, srcFrameStart = 0;
  logic [7:0] pixWrAddr = 0;
  logic [11:0] pixWrData = 0;
  logic [3:0] vgaR, vgaG, vgaB;
  logic vgaHsyncN, vgaVsyncN;

  line_upscaler #(
    .SRC_W(SW), .SRC_H(SH), .H_REP(HR), .V_REP(VR), .V_ACTIVE(VA),
    .H_FP(HFP), .H_SYNC(HS), .H_BP(HBP), .V_FP(VFP), .V_SYNC(VS), .V_BP(VBP),
    .NUM_BUFS(NB), .LOCK_LAG(LAG)
  ) u_line_upscaler (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit seenEdge = 0, done = 0;

  // behavioural reference model
  int mH, mV, mLc, mWs;
  bit mLocked, mArmed, inCoinc;
  logic [11:0] mBuf [NB][SW];
  logic [11:0] expRgb;
  logic expHs, expVs;
  string tagRgb, tagHs, tagVs;

  always @(posedge clk) begin
    bit act, same, restart;
    int rs;
    seenEdge = 1;
    cyc++;
    if (rst) begin
      mH = 0; mV = 0; mLc = 0; mWs = 0; mLocked = 0; mArmed = 0; inCoinc = 0;
      for (int s = 0; s < NB; s++) for (int x = 0; x < SW; x++) mBuf[s][x] = '0;
      expRgb = '0; expHs = 1; expVs = 1;
      tagRgb = "R1"; tagHs = "R1"; tagVs = "R1";
    end else begin
      act = mLocked && mH < HA && mV >= BRD && mV < IMG_END;
      rs = act ? ((mV - BRD) / VR) % NB : 0;
      expRgb = act ? mBuf[rs][mH / HR] : '0;
      same = act && pixWrEn && mWs == rs && int'(pixWrAddr) == mH / HR;
      expHs = !(mH >= HA + HFP && mH < HA + HFP + HS);
      expVs = !(mV >= VA + VFP && mV < VA + VFP + VS);
      tagRgb = !mLocked ? "R8" : same ? "R9" : !act ? "R4" : inCoinc ? "R10 R2 R3" : "R2 R3";
      tagHs = mLocked ? "R5 R7" : "R5";
      tagVs = mLocked ? "R6 R7" : "R6";
      if (pixWrEn && pixWrAddr < SW) mBuf[mWs][pixWrAddr] = pixWrData;
      restart = srcLineDone && !srcFrameStart && mArmed && mLc == LAG - 1;
      if (srcFrameStart) begin
        inCoinc = srcLineDone;
        mWs = 0; mLc = 0; mArmed = 1;
      end else if (srcLineDone) begin
        mWs = (mWs + 1) % NB;
        if (mArmed) begin
          mLc++;
          if (restart) mArmed = 0;
        end
      end
      if (restart) begin
        mH = 0; mV = 0; mLocked = 1;
      end else if (mH == HT - 1) begin
        mH = 0; mV = (mV == VT - 1) ? 0 : mV + 1;
      end else mH++;
    end
  end

  task automatic check(string tag, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (seenEdge && !done) begin
      check(tagRgb, {vgaR, vgaG, vgaB}, expRgb);
      check(tagHs, 12'(vgaHsyncN), 12'(expHs));
      check(tagVs, 12'(vgaVsyncN), 12'(expVs));
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startFrame(bit withLd);
    @(negedge clk); srcFrameStart = 1; srcLineDone = withLd;
    @(negedge clk); srcFrameStart = 0; srcLineDone = 0;
  endtask

  task automatic writeLine(int f, int l);
    for (int x = 0; x < SW; x++) begin
      @(negedge clk);
      pixWrEn = 1; pixWrAddr = 8'(x);
      pixWrData = 12'(f * 397 + l * 53 + x * 7 + 1);
    end
    @(negedge clk); pixWrEn = 0;
  endtask

  task automatic endLine();
    @(negedge clk); srcLineDone = 1;
    @(negedge clk); srcLineDone = 0;
  endtask

  // full source frame; skipLast leaves the final line-done to the next frame start
  task automatic sendFrame(int f, bit joinLd, bit skipLast);
    startFrame(joinLd);
    for (int l = 0; l < SH; l++) begin
      writeLine(f, l);
      idle(96 - SW - 3);
      if (!(skipLast && l == SH - 1)) endLine();
    end
    idle(300);
  endtask

  // write aimed at the cell being displayed (R9)
  task automatic aimedWrite(logic [11:0] val);
    int guard = 0;
    forever begin
      @(negedge clk);
      guard++;
      if (guard > 2000) begin
        errors++;
        $display("FAIL R9 aimed write never reached: actual=none expected=hit");
        break;
      end
      if (mLocked && mH < HA && mH % HR == 1 && mV >= BRD && mV < IMG_END &&
          ((mV - BRD) / VR) % NB == mWs) begin
        pixWrEn = 1; pixWrAddr = 8'(mH / HR); pixWrData = val;
        @(negedge clk); pixWrEn = 0;
        break;
      end
    end
  endtask

  initial begin
    idle(4);
    rst = 0;
    idle(700);                 // R8: free-running raster, no picture yet
    sendFrame(0, 0, 0);
    sendFrame(1, 0, 0);
    sendFrame(2, 0, 1);        // last line-done merged into next frame start
    sendFrame(3, 1, 0);        // R10
    startFrame(0);             // R9 frame: one line, then aimed writes
    writeLine(4, 0);
    endLine();
    aimedWrite(12'hA5C);
    idle(HT);
    aimedWrite(12'h3E7);
    idle(600);
    sendFrame(5, 0, 0);
    idle(700);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 60000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL R7 watchdog expired: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule